// File: doc/BRIEF.md
# Data-Ready Triggered Serial Sample Reader

This block sits on the host side of a read-only serial link from a delta-sigma converter. It watches the converter's active-low data-ready line. When that line falls, the block waits a programmable settle interval. It then drives a burst of serial clock pulses and shifts in one two's-complement sample, most significant bit first. Between bursts the serial clock rests low.

Each finished sample leaves the block left-justified in a 32-bit word, with the unused low bits cleared. A one-cycle strobe marks the word. The output has no back-pressure: the consumer must take the word in the strobe cycle, and nothing holds it for later. The block also keeps a sticky overrun flag. The flag is raised when a read still has bits left to capture inside the guard window before the next expected data-ready edge, or when a new edge arrives during such a read.

All timing comes from the system clock. Dividers and counts are parameters: system clocks per converter clock, system clocks per serial-clock phase, settle cycles, converter clocks per frame and guard length.

Top module: `adc_burst_reader`

## Requirements
- R1: `sclk` is low whenever no read burst is running, including during the settle interval and after reset.
- R2: A read starts only on a high-to-low transition of `drdy_n`, seen after a two-flip-flop synchronizer; a rising edge or a line that stays low starts nothing.
- R3: The first rising edge of `sclk` after an accepted data-ready fall comes no earlier than `SETTLE_CYC` system clocks after that fall.
- R4: Each read issues exactly `BITS` (default 24) rising edges on `sclk`.
- R5: Each high phase and each low phase of `sclk` in a burst lasts exactly `SCLK_HALF` system clocks, so the serial rate stays at or below half the converter clock when `SCLK_HALF >= MCLK_DIV`.
- R6: `sdata` is sampled at each rising edge of `sclk`; the first sampled bit is the sign (bit 23 of the sample), and later bits follow in falling significance.
- R7: The output word carries the sample in bits 31:8 and zeros in bits 7:0.
- R8: `word_valid` is high for exactly one system clock per read, starting the cycle after the last bit is captured, with `word_data` valid in that cycle.
- R9: Data-ready falls that arrive while a read is settling or bursting are ignored: that read completes with the originally shifted sample and no extra read follows.
- R10: `overrun` is set when a capture is still pending once `FRAME_MCLK - GUARD_MCLK` converter clocks have passed since the last data-ready fall, or when a data-ready fall arrives while a capture is pending; only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| sdata | input | 1 | Serial data from converter, asynchronous |
| sclk | output | 1 | Serial clock to converter, idles low |
| word_data | output | 32 | Left-justified sample word |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| overrun | output | 1 | Sticky flag: a read reached the guard window |

## Verification
The assertions take for granted that `drdy_n` and `sdata` are held for at least three system clocks, so the synchronizer sees every level. They also assume `sdata` changes only on a falling edge of `sclk`, so it has settled a full phase before the next rising edge. The bench drives data from a behavioural converter model that changes its bit only on `sclk` falling edges and reloads only between reads. It spaces data-ready falls a full frame apart, except in the one case that overlaps edges on purpose to exercise R9 and R10. A second instance with a shortened frame reaches the guard window without any edge overlap.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_BURST  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/adcrd_sync.sv
module adcrd_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
      end
    end
    assign q_o[g] = stab_q;
  end
endmodule

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
  parameter int SCLK_HALF = 4,
  parameter int BITS      = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic done_o
);
  localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int NEDGE = 2 * BITS;
  localparam int EW = $clog2(NEDGE);

  logic [HW-1:0] half_q;
  logic [EW-1:0] edge_q;
  logic          sclk_q;
  logic          term;

  assign term = run_i && (half_q == HW'(SCLK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      half_q <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
    end else if (term) begin
      half_q <= '0;
      edge_q <= edge_q + 1'b1;
      sclk_q <= ~sclk_q;
    end else begin
      half_q <= half_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = term && !sclk_q;
  assign done_o = term && (edge_q == EW'(NEDGE - 1));

  assert_stop_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sclk_o);
  assert_done_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> sclk_o);
endmodule

// File: rtl/adcrd_shifter.sv
module adcrd_shifter #(
  parameter int BITS   = 24,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic              all_taken_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int CW  = $clog2(BITS + 1);
  localparam int PAD = WORD_W - BITS;

  logic [BITS-1:0]   sh_q;
  logic [BITS-1:0]   sh_next;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic              take;
  logic              last;

  assign sh_next = {sh_q[BITS-2:0], bit_i};
  assign take    = rise_i && (cnt_q < CW'(BITS));
  assign last    = take && (cnt_q == CW'(BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last;
      if (clear_i) begin
        cnt_q <= '0;
      end else if (take) begin
        sh_q  <= sh_next;
        cnt_q <= cnt_q + 1'b1;
      end
      if (last) begin
        word_q <= {sh_next, {PAD{1'b0}}};
      end
    end
  end

  assign all_taken_o = (cnt_q == CW'(BITS));
  assign word_o      = word_q;
  assign valid_o     = valid_q;

  assert_no_extra_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |-> (cnt_q < CW'(BITS)));
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  if (PAD > 0) begin : g_pad_chk
    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (word_o[PAD-1:0] == '0));
  end
endmodule

// File: rtl/adcrd_guard.sv
module adcrd_guard #(
  parameter int MCLK_DIV   = 4,
  parameter int FRAME_MCLK = 64,
  parameter int GUARD_MCLK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic pending_i,
  output logic overrun_o
);
  localparam int DW = (MCLK_DIV > 1) ? $clog2(MCLK_DIV) : 1;
  localparam int PW = $clog2(FRAME_MCLK + 1);
  localparam int LIMIT = FRAME_MCLK - GUARD_MCLK;

  logic [DW-1:0] div_q;
  logic [PW-1:0] per_q;
  logic          ovr_q;
  logic          tick;
  logic          in_window;

  assign tick      = (div_q == DW'(MCLK_DIV - 1));
  assign in_window = (per_q >= PW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      per_q <= PW'(FRAME_MCLK);
      ovr_q <= 1'b0;
    end else begin
      if (fall_i) begin
        div_q <= '0;
        per_q <= '0;
      end else if (tick) begin
        div_q <= '0;
        if (per_q < PW'(FRAME_MCLK)) per_q <= per_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
      if (pending_i && (in_window || fall_i)) ovr_q <= 1'b1;
    end
  end

  assign overrun_o = ovr_q;

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(pending_i));
endmodule

// File: rtl/adc_burst_reader.sv
module adc_burst_reader #(
  parameter int MCLK_DIV   = 4,
  parameter int SCLK_HALF  = 4,
  parameter int SETTLE_CYC = 2,
  parameter int BITS       = 24,
  parameter int WORD_W     = 32,
  parameter int FRAME_MCLK = 64,
  parameter int GUARD_MCLK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drdy_n,
  input  logic              sdata,
  output logic              sclk,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic              overrun
);
  import adcrd_pkg::*;

  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [1:0]    sync_q;
  logic          drdy_s, sdata_s, drdy_d;
  logic          fall;
  rd_state_e     state_q;
  logic [SW-1:0] settle_q;
  logic          run, rise, done, all_taken, pending;

  adcrd_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({drdy_n, sdata}), .q_o(sync_q)
  );
  assign drdy_s  = sync_q[1];
  assign sdata_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drdy_d <= 1'b1;
    else        drdy_d <= drdy_s;
  end
  assign fall = drdy_d && !drdy_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      settle_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (fall) begin
          state_q  <= ST_SETTLE;
          settle_q <= '0;
        end
        ST_SETTLE: begin
          if (settle_q >= SW'(SETTLE_CYC - 1)) state_q <= ST_BURST;
          else settle_q <= settle_q + 1'b1;
        end
        ST_BURST: if (done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run = (state_q == ST_BURST);

  adcrd_sclk_gen #(.SCLK_HALF(SCLK_HALF), .BITS(BITS)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .sclk_o(sclk), .rise_o(rise), .done_o(done)
  );

  adcrd_shifter #(.BITS(BITS), .WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear_i(state_q == ST_SETTLE),
    .rise_i(rise), .bit_i(sdata_s), .all_taken_o(all_taken),
    .word_o(word_data), .valid_o(word_valid)
  );

  assign pending = (state_q != ST_IDLE) && !all_taken;

  adcrd_guard #(.MCLK_DIV(MCLK_DIV), .FRAME_MCLK(FRAME_MCLK),
                .GUARD_MCLK(GUARD_MCLK)) u_guard (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .pending_i(pending),
    .overrun_o(overrun)
  );

  assert_idle_sclk_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_BURST) |-> !sclk);
  assert_start_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !fall) |=> (state_q == ST_IDLE));
  assert_settle_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST && $past(state_q) == ST_SETTLE) |-> !sclk);
  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST && fall) |=> (state_q != ST_SETTLE));
endmodule

// File: tb/adc_burst_reader_tb_top.sv
module adc_burst_reader_tb_top;
  localparam int MDIV   = 2;
  localparam int HALF   = 4;
  localparam int SETTLE = 25;
  localparam int FRAME  = 320;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drdy_n = 1'b1;
  logic sdata;
  logic sclk, word_valid, overrun;
  logic [31:0] word_data;
  logic sclk_s, valid_s, overrun_s;
  logic [31:0] word_s;

  always #2 clk = ~clk;

  adc_burst_reader #(.MCLK_DIV(MDIV), .SCLK_HALF(HALF), .SETTLE_CYC(SETTLE),
    .BITS(24), .WORD_W(32), .FRAME_MCLK(160), .GUARD_MCLK(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .sdata(sdata), .sclk(sclk),
    .word_data(word_data), .word_valid(word_valid), .overrun(overrun));

  adc_burst_reader #(.MCLK_DIV(MDIV), .SCLK_HALF(HALF), .SETTLE_CYC(SETTLE),
    .BITS(24), .WORD_W(32), .FRAME_MCLK(100), .GUARD_MCLK(4)) dut_short_i (
    .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .sdata(sdata), .sclk(sclk_s),
    .word_data(word_s), .word_valid(valid_s), .overrun(overrun_s));

  // behavioural converter: bit changes on sclk falling edges
  logic [23:0] mdl_word = '0;
  int sclk_falls = 0;
  int mdl_base = 0;
  int mdl_idx;
  always @(negedge sclk) sclk_falls <= sclk_falls + 1;
  assign mdl_idx = sclk_falls - mdl_base;
  assign sdata = (mdl_idx >= 0 && mdl_idx < 24) ? mdl_word[23 - mdl_idx] : 1'b0;

  // monitor, sampled on the falling system clock edge
  int cyc = 0, rises = 0, valids = 0, fall_cyc = 0, delay = 0;
  int phase_len = 0, min_phase = 1000, max_phase = 0;
  bit armed = 0;
  logic sclk_p = 0, drdy_p = 1;
  logic [31:0] last_word = '0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    drdy_p <= drdy_n;
    sclk_p <= sclk;
    if (drdy_p && !drdy_n && !armed) begin
      fall_cyc <= cyc;
      armed <= 1;
    end
    if (sclk != sclk_p) begin
      if (sclk_p || phase_len < 50) begin
        if (phase_len + 1 < min_phase) min_phase <= phase_len + 1;
        if (phase_len + 1 > max_phase) max_phase <= phase_len + 1;
      end
      phase_len <= 0;
      if (sclk) begin
        rises <= rises + 1;
        if (armed) begin
          delay <= cyc - fall_cyc;
          armed <= 0;
        end
      end
    end else phase_len <= phase_len + 1;
    if (word_valid) begin
      valids <= valids + 1;
      last_word <= word_data;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fall_edge(input logic [23:0] s, input bit reload);
    @(posedge clk); #1;
    if (reload) begin
      mdl_word = s;
      mdl_base = sclk_falls;
    end
    drdy_n = 1'b0;
  endtask

  task automatic frame(input logic [23:0] s, input int low_len, input bit exp_ovr);
    int r0, v0;
    r0 = rises; v0 = valids;
    min_phase = 1000; max_phase = 0;
    fall_edge(s, 1);
    repeat (low_len) @(posedge clk);
    #1 drdy_n = 1'b1;
    repeat (FRAME - low_len) @(posedge clk);
    @(negedge clk);
    chk(valids - v0 == 1, "R8 one word per read", valids - v0, 1);
    chk(last_word == {s, 8'h00}, "R6/R7 word content", last_word, {s, 8'h00});
    chk(rises - r0 == 24, "R4 rising edges", rises - r0, 24);
    chk(delay >= SETTLE, "R3 settle delay", delay, SETTLE);
    chk(min_phase == HALF && max_phase == HALF, "R5 phase length", min_phase, HALF);
    chk(sclk == 1'b0, "R1 sclk idle low", sclk, 0);
    chk(overrun == exp_ovr, "R10 overrun main", overrun, exp_ovr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] lcg;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sclk == 0, "R1 reset sclk", sclk, 0);
    chk(word_valid == 0, "R8 reset valid", word_valid, 0);
    chk(overrun == 0, "R10 reset overrun", overrun, 0);
    #1 rst_n = 1'b1;
    repeat (20) @(posedge clk);
    // corner codes
    frame(24'h000000, 40, 0);
    chk(overrun_s == 1, "R10 short frame guard window", overrun_s, 1);
    frame(24'h000001, 40, 0);
    frame(24'hFFFFFF, 40, 0);
    frame(24'h7FFFFF, 40, 0);
    frame(24'h800000, 40, 0);
    frame(24'hAAAAAA, 40, 0);
    frame(24'h555555, 300, 0);   // R2: long low level, single read
    for (int i = 0; i < 24; i++) frame(24'h1 << i, 40, 0);
    lcg = 24'h13579B;
    for (int i = 0; i < 6; i++) begin
      lcg = lcg * 24'd1103 + 24'd12345;
      frame(lcg, 40, 0);
    end
    // R2: no read without a new falling edge
    begin
      int v0;
      v0 = valids;
      repeat (400) @(posedge clk);
      @(negedge clk);
      chk(valids == v0, "R2 no edge no read", valids - v0, 0);
    end
    // R9: second fall during burst is ignored
    begin
      int v0, r0;
      v0 = valids; r0 = rises;
      fall_edge(24'hC3A51E, 1);
      repeat (100) @(posedge clk);
      #1 drdy_n = 1'b1;
      repeat (10) @(posedge clk);
      fall_edge(24'h000000, 0);
      repeat (20) @(posedge clk);
      #1 drdy_n = 1'b1;
      repeat (FRAME) @(posedge clk);
      @(negedge clk);
      chk(valids - v0 == 1, "R9 single word despite extra edge", valids - v0, 1);
      chk(last_word == 32'hC3A51E00, "R9 word kept", last_word, 32'hC3A51E00);
      chk(rises - r0 == 24, "R9 one burst", rises - r0, 24);
      chk(overrun == 1, "R10 edge during pending read", overrun, 1);
    end
    frame(24'h0F0F0F, 40, 1);   // R10 sticky, reads continue
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule